// File: doc/BRIEF.md
# External Interrupt Sensitivity Unit

This block turns four groups of active-low external pins into four pending interrupt requests. Each pin first passes through a two-stage synchronizer. The pins of one group are then merged into a single group level, which is low whenever any pin of the group is low. Edge and level detection run on that merged level. A pending flag records each detected event and holds it until the CPU acknowledges it.

One configuration byte carries two 2-bit sensitivity fields, and each field governs two groups. The field code picks one of four behaviours: falling edge plus low level, rising edge, falling edge, or both edges. A field takes a new value only while the CPU global interrupt-mask flag is set. This keeps the trigger condition from changing under an interrupt that is already enabled. Vectoring and priority are left to the interrupt controller, which consumes `irq_o` and returns `ack_i`.

Top module: `ext_irq_sense_unit`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 00h and `irq_o` is 0. All synchronizer stages and the previous-level register reset to 1, so pins held high at reset produce no event.
- R2: Field code 00 sets pending on a falling group edge and also on every cycle the group level is low. An acknowledge while the level is low leaves the request asserted. Once the level is high again, an acknowledge clears it.
- R3: Field code 01 sets pending only on a rising group edge (all pins high again after at least one was low).
- R4: Field code 10 sets pending only on a falling group edge.
- R5: Field code 11 sets pending on both rising and falling group edges.
- R6: A write with `cfg_we_i`=1 updates the fields only when `irq_mask_i`=1. With `irq_mask_i`=0 both fields keep their old values, and the trigger behaviour is unchanged.
- R7: Bits 7:6 of the configuration byte control group 0 (`pins_i[3:0]`) and group 1 (`pins_i[7:4]`). Bits 4:3 control group 2 (`pins_i[11:8]`) and group 3 (`pins_i[14:12]`). Bits 5 and 2:0 read 0 and ignore writes.
- R8: The group level is low when any of its pins is low. A further pin going low, or one of several low pins returning high, while the group stays low is not an edge.
- R9: In edge codes, `ack_i[g]` clears pending g on the next clock unless a new event arrives in that same cycle. An acknowledge of one group leaves the other groups untouched.
- R10: A pin change applied before clock edge k shows on `irq_o` after clock edge k+2 (two synchronizer stages plus the pending register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 15 | Asynchronous active-low pins, groups packed from bit 0 |
| irq_mask_i | input | 1 | CPU global interrupt-mask flag; 1 unlocks field writes |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| ack_i | input | 4 | Per-group acknowledge strobes |
| irq_o | output | 4 | Per-group pending requests |
| cfg_rdata_o | output | 8 | Configuration readback |

## Verification
The bench sweeps every group against every field code. Each pass drives a fall, an acknowledge, a second pin in the same group and a release, so a wrong decode of one code shows up as a missing or extra request in exactly that group. The level code is pushed to acknowledge while the pin is still low; a design that treated 00 as a plain edge would drop the request there. Locked writes are followed by pin activity, so a design that leaked the write would change the trigger behaviour visibly. Mixed field values expose swapped field-to-group wiring, and a cycle-exact probe catches a synchronizer with a missing or extra stage.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_FALL_LOW = 2'b00,
    SENSE_RISE     = 2'b01,
    SENSE_FALL     = 2'b10,
    SENSE_BOTH     = 2'b11
  } sense_e;

  localparam int unsigned CFG_W      = 8;
  localparam int unsigned FLD_HI_LSB = 6;
  localparam int unsigned FLD_LO_LSB = 3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  // pins idle high; reset to ones so no edge appears on release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sense_cfg_reg.sv
module sense_cfg_reg
  import ext_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             unlock_i,
  input  logic [CFG_W-1:0] wdata_i,
  output sense_e           fld_hi_o,
  output sense_e           fld_lo_o,
  output logic [CFG_W-1:0] rdata_o
);
  sense_e fld_hi_q, fld_lo_q;
  logic   unused_bits;

  assign unused_bits = ^{wdata_i[5], wdata_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_hi_q <= SENSE_FALL_LOW;
      fld_lo_q <= SENSE_FALL_LOW;
    end else if (we_i && unlock_i) begin
      fld_hi_q <= sense_e'(wdata_i[FLD_HI_LSB +: 2]);
      fld_lo_q <= sense_e'(wdata_i[FLD_LO_LSB +: 2]);
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[FLD_HI_LSB +: 2] = fld_hi_q;
    rdata_o[FLD_LO_LSB +: 2] = fld_lo_q;
  end

  assign fld_hi_o = fld_hi_q;
  assign fld_lo_o = fld_lo_q;

  // R6
  locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlock_i) |=> ($stable(fld_hi_q) && $stable(fld_lo_q)));

  // R6
  open_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unlock_i) |=> (rdata_o[7:6] == $past(wdata_i[7:6]) &&
                            rdata_o[4:3] == $past(wdata_i[4:3])));

  // R7
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[5] == 1'b0) && (rdata_o[2:0] == 3'b000));
endmodule

// File: rtl/group_detect.sv
module group_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_s_i,
  input  sense_e       mode_i,
  input  logic         ack_i,
  output logic         irq_o
);
  logic lvl, lvl_q, rise, fall, evt, pend_q;

  // group reads low when any pin is low
  assign lvl  = &pin_s_i;
  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl;
  end

  always_comb begin
    unique case (mode_i)
      SENSE_FALL_LOW: evt = ~lvl;
      SENSE_RISE:     evt = rise;
      SENSE_FALL:     evt = fall;
      default:        evt = rise | fall;
    endcase
  end

  // event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (evt)   pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign irq_o = pend_q;

  // R2
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_FALL_LOW && !(&pin_s_i)) |=> irq_o);

  // R3
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == SENSE_RISE || mode_i == SENSE_BOTH) && (&pin_s_i) && !lvl_q) |=> irq_o);

  // R4
  fall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == SENSE_FALL || mode_i == SENSE_BOTH) && !(&pin_s_i) && lvl_q) |=> irq_o);

  // R8
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && mode_i != SENSE_FALL_LOW && ((&pin_s_i) == lvl_q)) |=> !irq_o);

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && mode_i != SENSE_FALL_LOW && ((&pin_s_i) == lvl_q)) |=> !irq_o);
endmodule

// File: rtl/ext_irq_sense_unit.sv
module ext_irq_sense_unit
  import ext_irq_pkg::*;
#(
  parameter int unsigned G0_W = 4,
  parameter int unsigned G1_W = 4,
  parameter int unsigned G2_W = 4,
  parameter int unsigned G3_W = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_GRP = 4,
  localparam int unsigned PIN_W   = G0_W + G1_W + G2_W + G3_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PIN_W-1:0]   pins_i,
  input  logic               irq_mask_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic [NUM_GRP-1:0] ack_i,
  output logic [NUM_GRP-1:0] irq_o,
  output logic [CFG_W-1:0]   cfg_rdata_o
);
  function automatic int unsigned grp_w(int unsigned g);
    case (g)
      0:       return G0_W;
      1:       return G1_W;
      2:       return G2_W;
      default: return G3_W;
    endcase
  endfunction

  function automatic int unsigned grp_off(int unsigned g);
    int unsigned o = 0;
    for (int unsigned i = 0; i < g; i++) o += grp_w(i);
    return o;
  endfunction

  sense_e fld_hi, fld_lo;

  sense_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .unlock_i (irq_mask_i),
    .wdata_i  (cfg_wdata_i),
    .fld_hi_o (fld_hi),
    .fld_lo_o (fld_lo),
    .rdata_o  (cfg_rdata_o)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned GW  = grp_w(g);
    localparam int unsigned OFF = grp_off(g);
    logic [GW-1:0] pin_s;
    sense_e        mode;

    // groups 0,1 follow the upper field, groups 2,3 the lower
    assign mode = (g < 2) ? fld_hi : fld_lo;

    pin_sync #(.W(GW), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pins_i[OFF +: GW]),
      .q_o    (pin_s)
    );

    group_detect #(.W(GW)) u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_s_i (pin_s),
      .mode_i  (mode),
      .ack_i   (ack_i[g]),
      .irq_o   (irq_o[g])
    );
  end
endmodule

// File: tb/ext_irq_sense_unit_test.sv
module ext_irq_sense_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] pins = '1;
  logic        mask = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [3:0]  ack = '0;
  logic [3:0]  irq;
  logic [7:0]  rdata;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .irq_mask_i(mask),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .ack_i(ack),
    .irq_o(irq), .cfg_rdata_o(rdata)
  );

  function automatic int wid(int g);
    return (g == 3) ? 3 : 4;
  endfunction

  function automatic int off(int g);
    return 4 * g;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(bit m, logic [7:0] d);
    mask = m; we = 1'b1; wdata = d;
    tick(1);
    we = 1'b0; mask = 1'b0;
  endtask

  task automatic pulse_ack(logic [3:0] a);
    ack = a;
    tick(1);
    ack = '0;
  endtask

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick(1);
    chk("R1 cfg", rdata, 8'h00);
    tick(4);
    chk("R1 irq", irq, 0);

    // R10 latency in fall mode
    wr(1'b1, 8'h90);
    pins[0] = 1'b0;
    tick(2);
    chk("R10 early", irq, 0);
    tick(1);
    chk("R10 on time", irq, 1);
    pins[0] = 1'b1;
    tick(4);
    pulse_ack(4'hf);
    chk("R9 ack", irq, 0);

    // R6 lock
    wr(1'b1, 8'h48);
    chk("R6 open write", rdata, 8'h48);
    wr(1'b0, 8'hff);
    chk("R6 locked write", rdata, 8'h48);
    pins[1] = 1'b0;
    tick(4);
    chk("R6 still rise mode on fall", irq, 0);
    pins[1] = 1'b1;
    tick(4);
    chk("R6 still rise mode on rise", irq, 1);
    pulse_ack(4'h1);
    wr(1'b1, 8'hff);
    chk("R7 spare bits", rdata, 8'hd8);

    // R7 field mapping: upper=fall, lower=rise
    wr(1'b1, 8'h88);
    pins[4] = 1'b0; pins[12] = 1'b0;
    tick(4);
    chk("R7 map fall", irq, 4'b0010);
    pins[4] = 1'b1; pins[12] = 1'b1;
    tick(4);
    chk("R7 map rise", irq, 4'b1010);
    pulse_ack(4'b1000);
    chk("R9 ack one group", irq, 4'b0010);
    pulse_ack(4'b0010);
    chk("R9 ack other", irq, 0);

    // sweep R2 R3 R4 R5 R8 over all groups and codes
    for (int m = 0; m < 4; m++) begin
      wr(1'b1, {m[1:0], 1'b0, m[1:0], 3'b000});
      for (int g = 0; g < 4; g++) begin
        int p = (g + m) % wid(g);
        int q = (p + 1) % wid(g);
        string r = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        pins[off(g) + p] = 1'b0;
        tick(4);
        chk({r, " fall"}, irq, (m != 1) << g);
        pulse_ack(4'hf);
        chk({r, " ack while low"}, irq, (m == 0) << g);
        pins[off(g) + q] = 1'b0;
        tick(4);
        chk("R8 second pin low", irq, (m == 0) << g);
        pins[off(g) + q] = 1'b1;
        tick(4);
        chk("R8 partial release", irq, (m == 0) << g);
        pins[off(g) + p] = 1'b1;
        tick(4);
        chk({r, " rise"}, irq, (m != 2) << g);
        pulse_ack(4'hf);
        chk({r, " ack high"}, irq, 0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule